// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the two low-order address bits of a four-beat memory burst. When an address strobe is accepted, it captures the starting low bits and the burst order. After that it generates each following beat address itself. The counter moves forward only on clock edges where the advance input is high. Between those edges the current address stays where it is, so a slow consumer can stretch the burst.

Two orders are available. Interleaved order visits `start XOR n`. Linear order visits `(start + n) mod 4` and wraps around. The order is sampled once, at load, and stays fixed for the rest of the burst. A flag marks the fourth beat. The upper address bits pass around this block unchanged.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is 0 and `last_o` is 0.
- R2: After a rising edge with `load_i` = 1, `addr_o` equals the `start_i` sampled at that edge and `last_o` is 0.
- R3: With `order_i` = 0 (interleaved) at load, beat n (n = 0..3, counted in accepted advances since load) presents `start XOR n`.
- R4: With `order_i` = 1 (linear) at load, beat n presents `(start + n) mod 4`.
- R5: An edge with `load_i` = 0 and `adv_i` = 0 leaves `addr_o` and `last_o` unchanged.
- R6: `last_o` is 1 exactly while the fourth beat (n = 3) is presented.
- R7: An advance while `last_o` = 1 returns `addr_o` to the start value and clears `last_o`.
- R8: `load_i` takes priority over `adv_i`. A load during a burst restarts at beat 0 with the new start.
- R9: Changes on `order_i` while `load_i` = 0 do not change the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Address strobe accepted: capture start and order |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | Burst order: 0 interleaved, 1 linear |
| start_i | input | 2 | Starting low address bits |
| addr_o | output | 2 | Current beat address bits |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench covers every start value in both orders. This separates an XOR map from an add map, since the two agree only for some starts; a swapped or half-correct map shows wrong addresses at beats 1 to 3.

It inserts idle cycles between advances, so a counter that free-runs gives itself away. It also continues past the fourth beat, where a design that saturates instead of wrapping would stick at the last address.

A reload that arrives together with an advance catches wrong priority, because the beat would be skipped. Toggling the order pin mid-burst exposes a design that reads the pin live instead of the captured copy.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_LIN = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_ctr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             order_i,
  input  logic [CNT_W-1:0] start_i,
  output logic [CNT_W-1:0] start_o,
  output burst_order_e     order_o
);
  logic [CNT_W-1:0] start_q;
  burst_order_e     order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      order_q <= ORDER_XOR;
    end else if (load_i) begin
      start_q <= start_i;
      order_q <= burst_order_e'(order_i);
    end
  end

  assign start_o = start_q;
  assign order_o = order_q;

  // order is frozen for the burst
  assert_order_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_q));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] BEAT_LAST = '1;
  localparam logic [CNT_W-1:0] BEAT_PEN  = BEAT_LAST - CNT_W'(1);

  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (load_i)  beat_q <= '0;
    else if (adv_i)   beat_q <= beat_q + CNT_W'(1);
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == BEAT_LAST);

  assert_last_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && adv_i && beat_q == BEAT_PEN |=> last_o);
  assert_beat_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && adv_i && last_o |=> beat_q == '0);
  assert_load_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_q == '0);
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_ctr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] addr_o
);
  logic [CNT_W-1:0] lin_addr;
  logic [CNT_W-1:0] xor_addr;

  assign lin_addr = start_i + beat_i;
  assign xor_addr = start_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      ORDER_LIN: addr_o = lin_addr;
      default:   addr_o = xor_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_ctr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             order_i,
  input  logic [CNT_W-1:0] start_i,
  output logic [CNT_W-1:0] addr_o,
  output logic             last_o
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;
  burst_order_e     order_q;

  burst_start_reg #(.CNT_W(CNT_W)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .order_i(order_i),
    .start_i(start_i), .start_o(start_q), .order_o(order_q)
  );

  burst_beat_cnt #(.CNT_W(CNT_W)) u_beat (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .adv_i(adv_i),
    .beat_o(beat_q), .last_o(last_o)
  );

  burst_seq_map #(.CNT_W(CNT_W)) u_map (
    .start_i(start_q), .beat_i(beat_q), .order_i(order_q), .addr_o(addr_o)
  );

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_i) && !last_o);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !adv_i |=> $stable(addr_o) && $stable(last_o));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && adv_i && last_o |=> addr_o == start_q && !last_o);
endmodule

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0, adv = 1'b0, order = 1'b0;
  logic [1:0] start = 2'd0;
  logic [1:0] addr;
  logic       last;

  int total = 0, bad = 0;

  typedef struct {
    logic [1:0] a;
    logic       l;
    string      req;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_start = 2'd0, m_beat = 2'd0;
  logic       m_order = 1'b0;

  always #2 clk = ~clk;

  burst_addr_ctr uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .adv_i(adv),
    .order_i(order), .start_i(start), .addr_o(addr), .last_o(last)
  );

  task automatic check(input logic [1:0] a, input logic l,
                       input logic [1:0] ea, input logic el, input string req);
    total++;
    if (a !== ea || l !== el) begin
      bad++;
      $display("FAIL %s: addr=%0d last=%0d expected addr=%0d last=%0d", req, a, l, ea, el);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed for after the edge
  task automatic step(input logic ld, input logic av, input logic od,
                      input logic [1:0] st, input string req);
    exp_t e;
    @(negedge clk);
    load = ld; adv = av; order = od; start = st;
    if (ld) begin
      m_start = st; m_order = od; m_beat = 2'd0;
    end else if (av) begin
      m_beat = m_beat + 2'd1;
    end
    e.a = m_order ? (m_start + m_beat) : (m_start ^ m_beat);
    e.l = (m_beat == 2'd3);
    e.req = req;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(addr, last, e.a, e.l, e.req);
    end
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    check(addr, last, 2'd0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // every start, both orders, full burst plus wrap
    for (int od = 0; od < 2; od++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 1'b0, od[0], s[1:0], "R2");
        for (int n = 1; n < 4; n++)
          step(1'b0, 1'b1, od[0], 2'd0, od ? "R4" : "R3");
        step(1'b0, 1'b0, od[0], 2'd0, "R6");
        step(1'b0, 1'b1, od[0], 2'd0, "R7");
      end
    end

    // stalls between advances
    step(1'b1, 1'b0, 1'b1, 2'd2, "R2");
    step(1'b0, 1'b0, 1'b0, 2'd1, "R5");
    step(1'b0, 1'b1, 1'b0, 2'd1, "R4");
    step(1'b0, 1'b0, 1'b1, 2'd3, "R5");
    step(1'b0, 1'b0, 1'b0, 2'd0, "R5");
    step(1'b0, 1'b1, 1'b1, 2'd0, "R4");

    // order pin toggled mid-burst
    step(1'b1, 1'b0, 1'b0, 2'd1, "R2");
    step(1'b0, 1'b1, 1'b1, 2'd0, "R9");
    step(1'b0, 1'b1, 1'b1, 2'd0, "R9");
    step(1'b0, 1'b1, 1'b0, 2'd0, "R9");

    // reload with advance in the same cycle, mid-burst and on last beat
    step(1'b1, 1'b0, 1'b1, 2'd3, "R2");
    step(1'b0, 1'b1, 1'b1, 2'd0, "R4");
    step(1'b1, 1'b1, 1'b0, 2'd2, "R8");
    step(1'b0, 1'b1, 1'b0, 2'd0, "R8");
    step(1'b0, 1'b1, 1'b0, 2'd0, "R3");
    step(1'b0, 1'b1, 1'b0, 2'd0, "R6");
    step(1'b1, 1'b1, 1'b1, 2'd1, "R8");
    step(1'b0, 1'b1, 1'b1, 2'd0, "R8");

    // long run of advances: second wrap
    for (int n = 0; n < 8; n++)
      step(1'b0, 1'b1, 1'b0, 2'd0, "R7");

    @(negedge clk);
    load = 1'b0; adv = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule